// File: doc/BRIEF.md
# Core Thread-Partition Mode Controller

This block decides how an eight-thread processor core is divided into subcores: one subcore of eight threads, two subcores of four, or four subcores of two. A 3-bit configuration write carries a hold bit, which blocks automatic merging, and two split-request bits. The block follows the rule that a split is only ever entered from the unsplit state. A legal request starts a fixed countdown, and the new mode becomes visible when the countdown ends.

Leaving a split mode is never requested directly. The core merges back to one subcore by itself when the hold bit is clear and every thread except thread 0 reports that it is napping. For every thread the block drives a subcore index and a sibling mask, which marks the threads that share its subcore. These outputs come from the same mode register as the two status bits, so they change on the same edge.

Top module: `core_partition_ctrl`

## Requirements
- R1: After reset the core is unsplit. `hold_o`, `split2_o`, `split4_o` and `err_o` are 0, every subcore index is 0 and every sibling mask is all ones.
- R2: In the two-subcore mode, threads 0–3 have index 0 and mask 0x0F, and threads 4–7 have index 1 and mask 0xF0.
- R3: In the four-subcore mode, thread t has index t/2 and mask 0x3 shifted left by 2·(t/2).
- R4: A write with bit 0 (hold) set and exactly one of bit 1 (split to two) or bit 2 (split to four) set is accepted only while the core is unsplit and no split is counting down. Both status bits stay 0 until exactly SPLIT_DELAY clock edges after the accepting edge, and then the matching bit is set.
- R5: A split request whose hold bit is 0 starts no split. The write still stores hold = 0.
- R6: A split request made while the core is split or while a split is counting down has no effect on the mode. This includes a direct move between the two split modes.
- R7: When `hold_o` is 0, the core is split and `nap_i[7:1]` are all 1, the core is unsplit after the next edge. The value of `nap_i[0]` does not matter.
- R8: While `hold_o` is 1, napping threads never unsplit the core.
- R9: A write with bits 1 and 2 both set is ignored completely, including the hold bit. `err_o` is 1 for exactly the one cycle after that write's edge.
- R10: The automatic merge uses the hold value held before the edge. A write in the same cycle affects only later cycles.
- R11: The status bits, indices and masks all change together on a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Bit 0 hold, bit 1 split-to-two request, bit 2 split-to-four request |
| nap_i | input | 8 | Per-thread napping status |
| hold_o | output | 1 | Stored hold bit |
| split2_o | output | 1 | Core is in the two-subcore mode |
| split4_o | output | 1 | Core is in the four-subcore mode |
| err_o | output | 1 | Pulse: a write carried both split requests |
| subcore_idx_o | output | 16 | Subcore index, 2 bits per thread, thread 0 in the low bits |
| sibling_mask_o | output | 64 | Sibling mask, 8 bits per thread, thread 0 in the low bits |

## Verification
The configuration write and the automatic merge can act on the same edge. For example, a write that sets or clears hold can arrive just as the napping condition is met, and a write carrying both split requests can arrive on a merge edge. The bench provokes these pairings directly, and random writes mixed with nap vectors biased toward all-napping provoke them further. A per-cycle model judges each outcome using the hold value from before the edge. It checks that a rejected write never blocks or delays a merge.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    MODE_WHOLE   = 2'd0,
    MODE_HALF    = 2'd1,
    MODE_QUARTER = 2'd2
  } part_mode_e;

  localparam int CFG_W        = 3;
  localparam int CFG_HOLD_BIT = 0;
  localparam int CFG_TO2_BIT  = 1;
  localparam int CFG_TO4_BIT  = 2;
  localparam int IDX_W        = 2;
endpackage

// File: rtl/cpc_cfg_decode.sv
module cpc_cfg_decode
  import cpc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             idle_i,
  output logic             hold_o,
  output logic             err_o,
  output logic             start_o,
  output part_mode_e       start_tgt_o
);
  logic to2, to4, both, legal_we;

  assign to2      = wdata_i[CFG_TO2_BIT];
  assign to4      = wdata_i[CFG_TO4_BIT];
  assign both     = to2 & to4;
  assign legal_we = we_i & ~both;

  // split needs hold set in the same write, one target, and an idle unsplit core
  assign start_o     = legal_we & wdata_i[CFG_HOLD_BIT] & (to2 ^ to4) & idle_i;
  assign start_tgt_o = to4 ? MODE_QUARTER : MODE_HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (legal_we) hold_o <= wdata_i[CFG_HOLD_BIT];
      err_o <= we_i & both;
    end
  end
endmodule

// File: rtl/cpc_sequencer.sv
module cpc_sequencer
  import cpc_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int SPLIT_DELAY = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  part_mode_e             start_tgt_i,
  input  logic                   hold_i,
  input  logic [NUM_THREADS-1:0] nap_i,
  output part_mode_e             mode_o,
  output logic                   idle_o
);
  localparam int CW = $clog2(SPLIT_DELAY + 1);

  part_mode_e    mode_q, tgt_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          others_nap, auto_merge, last_tick;

  // thread 0 is excluded from the napping condition
  assign others_nap = &(nap_i | {{(NUM_THREADS-1){1'b0}}, 1'b1});
  assign auto_merge = ~hold_i & others_nap & (mode_q != MODE_WHOLE);
  assign last_tick  = pend_q & (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_WHOLE;
      tgt_q  <= MODE_WHOLE;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (auto_merge)     mode_q <= MODE_WHOLE;
      else if (last_tick) mode_q <= tgt_q;

      if (start_i) begin
        pend_q <= 1'b1;
        cnt_q  <= CW'(SPLIT_DELAY);
        tgt_q  <= start_tgt_i;
      end else if (pend_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_tick) pend_q <= 1'b0;
      end
    end
  end

  assign mode_o = mode_q;
  assign idle_o = (mode_q == MODE_WHOLE) & ~pend_q;
endmodule

// File: rtl/cpc_thread_map.sv
module cpc_thread_map
  import cpc_pkg::*;
#(
  parameter int NUM_THREADS = 8
) (
  input  part_mode_e                       mode_i,
  output logic [NUM_THREADS*IDX_W-1:0]     idx_o,
  output logic [NUM_THREADS*NUM_THREADS-1:0] mask_o
);
  localparam int TPS2 = NUM_THREADS / 2;
  localparam int TPS4 = NUM_THREADS / 4;
  localparam logic [NUM_THREADS-1:0] ONES = {NUM_THREADS{1'b1}};

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    localparam int IDX2 = g / TPS2;
    localparam int IDX4 = g / TPS4;
    localparam logic [NUM_THREADS-1:0] MASK2 = (ONES >> (NUM_THREADS - TPS2)) << (IDX2 * TPS2);
    localparam logic [NUM_THREADS-1:0] MASK4 = (ONES >> (NUM_THREADS - TPS4)) << (IDX4 * TPS4);

    always_comb begin
      unique case (mode_i)
        MODE_HALF: begin
          idx_o[g*IDX_W +: IDX_W]                   = IDX_W'(IDX2);
          mask_o[g*NUM_THREADS +: NUM_THREADS]      = MASK2;
        end
        MODE_QUARTER: begin
          idx_o[g*IDX_W +: IDX_W]                   = IDX_W'(IDX4);
          mask_o[g*NUM_THREADS +: NUM_THREADS]      = MASK4;
        end
        default: begin
          idx_o[g*IDX_W +: IDX_W]                   = '0;
          mask_o[g*NUM_THREADS +: NUM_THREADS]      = ONES;
        end
      endcase
    end
  end
endmodule

// File: rtl/core_partition_ctrl.sv
module core_partition_ctrl
  import cpc_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int SPLIT_DELAY = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cfg_we_i,
  input  logic [CFG_W-1:0]                   cfg_wdata_i,
  input  logic [NUM_THREADS-1:0]             nap_i,
  output logic                               hold_o,
  output logic                               split2_o,
  output logic                               split4_o,
  output logic                               err_o,
  output logic [NUM_THREADS*IDX_W-1:0]       subcore_idx_o,
  output logic [NUM_THREADS*NUM_THREADS-1:0] sibling_mask_o
);
  logic       idle, start;
  part_mode_e start_tgt, mode;

  cpc_cfg_decode u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .idle_i      (idle),
    .hold_o      (hold_o),
    .err_o       (err_o),
    .start_o     (start),
    .start_tgt_o (start_tgt)
  );

  cpc_sequencer #(
    .NUM_THREADS (NUM_THREADS),
    .SPLIT_DELAY (SPLIT_DELAY)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_tgt_i (start_tgt),
    .hold_i      (hold_o),
    .nap_i       (nap_i),
    .mode_o      (mode),
    .idle_o      (idle)
  );

  cpc_thread_map #(
    .NUM_THREADS (NUM_THREADS)
  ) u_map (
    .mode_i (mode),
    .idx_o  (subcore_idx_o),
    .mask_o (sibling_mask_o)
  );

  assign split2_o = (mode == MODE_HALF);
  assign split4_o = (mode == MODE_QUARTER);
endmodule

// File: rtl/core_partition_ctrl_chk.sv
module core_partition_ctrl_chk
  import cpc_pkg::*;
#(
  parameter int NUM_THREADS = 8
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               cfg_we_i,
  input logic [CFG_W-1:0]                   cfg_wdata_i,
  input logic [NUM_THREADS-1:0]             nap_i,
  input logic                               hold_o,
  input logic                               split2_o,
  input logic                               split4_o,
  input logic                               err_o,
  input logic [NUM_THREADS*IDX_W-1:0]       subcore_idx_o,
  input logic [NUM_THREADS*NUM_THREADS-1:0] sibling_mask_o
);
  localparam int LT = NUM_THREADS - 1;

  logic others_nap;
  assign others_nap = &nap_i[NUM_THREADS-1:1];

  assert_mode_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({split2_o, split4_o}));

  assert_no_cross_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split2_o |=> !split4_o);

  assert_no_cross4_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split4_o |=> !split2_o);

  assert_auto_merge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && others_nap && (split2_o || split4_o)) |=> !(split2_o || split4_o));

  assert_hold_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && split2_o) |=> split2_o);

  assert_hold_blocks4_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && split4_o) |=> split4_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[CFG_TO2_BIT] && cfg_wdata_i[CFG_TO4_BIT]) |=> err_o);

  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_wdata_i[CFG_TO2_BIT] && cfg_wdata_i[CFG_TO4_BIT]) |=> !err_o);

  assert_hold_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[CFG_TO2_BIT] && cfg_wdata_i[CFG_TO4_BIT]) |=> $stable(hold_o));

  assert_last_idx_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    subcore_idx_o[LT*IDX_W +: IDX_W] ==
      (split4_o ? IDX_W'(3) : split2_o ? IDX_W'(1) : IDX_W'(0)));

  assert_mask_size_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sibling_mask_o[NUM_THREADS-1:0]) ==
      (split4_o ? NUM_THREADS/4 : split2_o ? NUM_THREADS/2 : NUM_THREADS));
endmodule

bind core_partition_ctrl core_partition_ctrl_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_we_i       (cfg_we_i),
  .cfg_wdata_i    (cfg_wdata_i),
  .nap_i          (nap_i),
  .hold_o         (hold_o),
  .split2_o       (split2_o),
  .split4_o       (split4_o),
  .err_o          (err_o),
  .subcore_idx_o  (subcore_idx_o),
  .sibling_mask_o (sibling_mask_o)
);

// File: tb/core_partition_ctrl_bench.sv
module core_partition_ctrl_bench;
  localparam int NT    = 8;
  localparam int DLY   = 4;
  localparam int TCLK  = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_wdata_i = '0;
  logic [NT-1:0] nap_i = '0;
  logic          hold_o, split2_o, split4_o, err_o;
  logic [2*NT-1:0]  subcore_idx_o;
  logic [NT*NT-1:0] sibling_mask_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state: mode 0 whole, 1 half, 2 quarter
  int   m_mode, m_tgt, m_cnt;
  bit   m_hold, m_pend, m_err;

  always #(TCLK/2) clk_i = ~clk_i;

  core_partition_ctrl #(.NUM_THREADS(NT), .SPLIT_DELAY(DLY)) u_core_partition_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .nap_i,
    .hold_o, .split2_o, .split4_o, .err_o, .subcore_idx_o, .sibling_mask_o
  );

  function automatic logic [2*NT-1:0] exp_idx(int mode);
    logic [2*NT-1:0] v;
    for (int t = 0; t < NT; t++) begin
      int tps = NT >> mode;
      v[t*2 +: 2] = 2'(t / tps);
    end
    return v;
  endfunction

  function automatic logic [NT*NT-1:0] exp_mask(int mode);
    logic [NT*NT-1:0] v;
    for (int t = 0; t < NT; t++) begin
      int tps = NT >> mode;
      int grp = t / tps;
      v[t*NT +: NT] = NT'(((1 << tps) - 1) << (grp * tps));
    end
    return v;
  endfunction

  task automatic check_now(input string tag);
    logic [3:0] st_a, st_e;
    st_a = {err_o, hold_o, split4_o, split2_o};
    st_e = {m_err, m_hold, m_mode == 2, m_mode == 1};
    checks++;
    if (st_a !== st_e || subcore_idx_o !== exp_idx(m_mode) || sibling_mask_o !== exp_mask(m_mode)) begin
      errors++;
      $display("FAIL %s: status act=%h exp=%h idx act=%h exp=%h mask act=%h exp=%h",
               tag, st_a, st_e, subcore_idx_o, exp_idx(m_mode), sibling_mask_o, exp_mask(m_mode));
    end
  endtask

  // called at a negedge: drive, take one edge, update model, check at next negedge
  task automatic step(input bit we, input logic [2:0] d, input logic [NT-1:0] nap, input string tag);
    bit both, auto, start, n_hold, n_pend;
    int n_mode, n_cnt, n_tgt;
    cfg_we_i = we; cfg_wdata_i = d; nap_i = nap;
    @(posedge clk_i);
    both   = we && d[1] && d[2];
    auto   = !m_hold && (&nap[NT-1:1]) && m_mode != 0;
    start  = we && !both && d[0] && (d[1] ^ d[2]) && m_mode == 0 && !m_pend;
    n_hold = (we && !both) ? d[0] : m_hold;
    n_mode = m_mode; n_pend = m_pend; n_cnt = m_cnt; n_tgt = m_tgt;
    if (auto) n_mode = 0;
    else if (m_pend && m_cnt == 1) n_mode = m_tgt;
    if (start) begin
      n_pend = 1; n_cnt = DLY; n_tgt = d[2] ? 2 : 1;
    end else if (m_pend) begin
      n_cnt = m_cnt - 1;
      if (m_cnt == 1) n_pend = 0;
    end
    m_err = both; m_hold = n_hold; m_mode = n_mode;
    m_pend = n_pend; m_cnt = n_cnt; m_tgt = n_tgt;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    check_now(tag);
  endtask

  task automatic idle(input int n, input logic [NT-1:0] nap, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 3'b000, nap, tag);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    m_mode = 0; m_tgt = 0; m_cnt = 0; m_hold = 0; m_pend = 0; m_err = 0;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_now("R1 reset state");
    idle(2, '0, "R1 idle after reset");

    // R5: request without hold
    step(1'b1, 3'b010, '0, "R5 request without hold");
    idle(DLY + 1, '0, "R5 no split follows");

    // R4 + R2: split to two, status clear during countdown
    step(1'b1, 3'b011, '0, "R4 split2 accepted");
    // R6: request during countdown is ignored
    step(1'b1, 3'b101, '0, "R6 request while counting");
    idle(DLY, '0, "R4 R2 countdown then two-way map");

    // R6: direct move to four refused
    step(1'b1, 3'b101, '0, "R6 split2 to split4 refused");
    idle(2, '0, "R6 mode kept");

    // R8: hold set, everyone napping
    idle(4, 8'hFF, "R8 hold blocks merge");

    // R10: clear hold while napping; merge only the edge after
    step(1'b1, 3'b000, 8'hFE, "R10 hold cleared same cycle");
    step(1'b0, 3'b000, 8'hFE, "R7 merge after hold clear");

    // R3: split to four
    step(1'b1, 3'b101, '0, "R4 split4 accepted");
    idle(DLY + 1, 8'h01, "R3 four-way map");

    // R7 with thread 0 awake and R10: setting hold on a merge edge does not block it
    step(1'b1, 3'b000, '0, "R7 hold cleared");
    step(1'b1, 3'b001, 8'hFE, "R10 hold set on merge edge");
    idle(2, 8'hFE, "R7 merged");

    // R9: double request ignored, hold kept, one-cycle pulse
    step(1'b1, 3'b111, '0, "R9 double request");
    step(1'b0, 3'b000, '0, "R9 pulse ends");
    step(1'b1, 3'b110, '0, "R9 double request keeps hold");
    idle(DLY + 1, '0, "R9 no split started");

    // R11 and random mix
    for (int i = 0; i < 600; i++) begin
      bit we;
      logic [2:0] d;
      logic [NT-1:0] nap;
      we  = ($urandom % 3) == 0;
      d   = 3'($urandom);
      nap = (($urandom % 2) == 0) ? (8'hFE | 8'($urandom)) : 8'($urandom);
      step(we, d, nap, "R11 random mix");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule